// File: doc/BRIEF.md
# Recursive Interpolating Upsampler

This block sits in front of a delta-sigma modulator, one instance per audio channel. It takes signed samples at the base audio rate over a valid/ready handshake. It repeats each sample a fixed power-of-two number of times, which is a zero-order hold. The repeated stream is smoothed with a single-pole recursive low-pass filter whose coefficient is a right shift. The modulator therefore receives a denser and smoother sequence of values.

A strobe input sets the output rate. Each strobe that finds a repetition still pending advances the filter by one step and produces one output sample on the next cycle. The handshake holds off the source until all repetitions of the current sample have been consumed.

A bypass input lets the modulator run without upsampling. In bypass, every accepted sample appears unchanged at the output one cycle later, and the filter state is loaded with that sample. Leaving bypass then starts the filter from the last value it passed.

Top module: `ups_iir_interp`

## Requirements
- R1: While reset is asserted and on the first cycle after it, out_valid is 0 and in_ready is 1. Reset clears the filter state to zero, so the first output after reset for an input x equals (x + 2^(K-1)) >>> K.
- R2: A sample is taken on a rising clock edge where in_valid and in_ready are both 1. With bypass low, in_ready is 0 from the next cycle until L strobes have been consumed for that sample. in_ready returns to 1 on the cycle after the L-th consumed strobe.
- R3: Each consumed strobe produces exactly one out_valid pulse, on the cycle after the strobe. Each sample taken with bypass low yields exactly L output pulses.
- R4: The filter state y is a signed value with K fractional bits. Each consumed strobe with held sample x updates it as y = y + ((x·2^K − y) >>> K), where >>> is an arithmetic shift (floor).
- R5: With bypass low, out_data equals the updated y rounded as (y + 2^(K-1)) >>> K and clipped to the signed range of W bits.
- R6: A strobe produces no pulse and leaves the filter state unchanged in two cases: when no repetition is pending, and when it falls in the same cycle as a sample being taken.
- R7: With bypass high, in_ready is constantly 1. A taken sample appears unchanged on out_data with out_valid high on the next cycle, and strobes produce nothing.
- R8: A sample taken in bypass loads the filter state with x·2^K. A later filtered run on the same x therefore outputs x on every one of its L pulses.
- R9: out_data keeps its value in every cycle where out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bypass | input | 1 | 1: pass samples straight through at the base rate |
| in_valid | input | 1 | Input sample is present |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_data | input | W | Signed input sample |
| out_strobe | input | 1 | Output-rate tick that advances the filter |
| out_valid | output | 1 | out_data carries a new sample this cycle |
| out_data | output | W | Signed output sample |

## Verification
A strobe and the acceptance of a new sample can fall in the same cycle. The bench provokes this by raising in_valid and out_strobe on the same clock edge while in_ready is high. It then expects no output pulse on the next cycle, in_ready already low, and exactly L further strobes needed before the next sample is taken. It also places a strobe in the same cycle as a bypass acceptance, and expects a single pulse carrying the raw sample.

// File: rtl/ups_pkg.sv
package ups_pkg;

    typedef enum logic {
        MODE_FILTER = 1'b0,
        MODE_PASS   = 1'b1
    } ups_mode_e;

endpackage

// File: rtl/ups_hold.sv
module ups_hold
    import ups_pkg::*;
#(
    parameter int W = 16,
    parameter int L = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  ups_mode_e    mode,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    input  logic         strobe,
    output logic         ready,
    output logic         take,
    output logic         step,
    output logic [W-1:0] held
);
    localparam int CW = $clog2(L + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [W-1:0]  x;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        ready = (mode == MODE_PASS) || (st_q.cnt == '0);
        take  = in_valid && ready;
        step  = (mode == MODE_FILTER) && strobe && (st_q.cnt != '0);
        if (take) begin
            st_d.x = in_data;
        end
        if (mode == MODE_PASS) begin
            st_d.cnt = '0;
        end else if (take) begin
            st_d.cnt = CW'(L);
        end else if (step) begin
            st_d.cnt = st_q.cnt - CW'(1);
        end
        held = st_q.x;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/ups_iir.sv
module ups_iir #(
    parameter int W = 16,
    parameter int K = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_x,
    input  logic         step,
    input  logic [W-1:0] x,
    output logic [W-1:0] y_next
);
    localparam int AW = W + K + 2;
    localparam logic signed [AW-1:0] MAXV = {{(AW-W+1){1'b0}}, {(W-1){1'b1}}};
    localparam logic signed [AW-1:0] MINV = {{(AW-W+1){1'b1}}, {(W-1){1'b0}}};
    localparam logic signed [AW-1:0] HALF = AW'(1) <<< (K - 1);

    typedef struct packed {
        logic signed [AW-1:0] acc;
    } iir_t;

    iir_t st_d, st_q;

    logic signed [AW-1:0] x_ext;
    logic signed [AW-1:0] ld_ext;
    logic signed [AW-1:0] diff;
    logic signed [AW-1:0] rnd;

    always_comb begin
        st_d   = st_q;
        x_ext  = $signed({{(AW-W){x[W-1]}}, x}) <<< K;
        ld_ext = $signed({{(AW-W){load_x[W-1]}}, load_x}) <<< K;
        diff   = x_ext - st_q.acc;
        if (load) begin
            st_d.acc = ld_ext;
        end else if (step) begin
            st_d.acc = st_q.acc + (diff >>> K);
        end
        rnd = (st_d.acc + HALF) >>> K;
        if (rnd > MAXV) begin
            y_next = MAXV[W-1:0];
        end else if (rnd < MINV) begin
            y_next = MINV[W-1:0];
        end else begin
            y_next = rnd[W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/ups_iir_interp.sv
module ups_iir_interp
    import ups_pkg::*;
#(
    parameter int W = 16,
    parameter int L = 8,
    parameter int K = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bypass,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    input  logic         out_strobe,
    output logic         out_valid,
    output logic [W-1:0] out_data
);
    typedef struct packed {
        logic         vld;
        logic [W-1:0] dat;
    } out_t;

    ups_mode_e    mode;
    logic         take;
    logic         step;
    logic [W-1:0] held;
    logic [W-1:0] y_next;
    out_t         o_d, o_q;

    assign mode = bypass ? MODE_PASS : MODE_FILTER;

    ups_hold #(.W(W), .L(L)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .in_valid (in_valid),
        .in_data  (in_data),
        .strobe   (out_strobe),
        .ready    (in_ready),
        .take     (take),
        .step     (step),
        .held     (held)
    );

    ups_iir #(.W(W), .K(K)) u_iir (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (take && (mode == MODE_PASS)),
        .load_x (in_data),
        .step   (step),
        .x      (held),
        .y_next (y_next)
    );

    always_comb begin
        o_d     = o_q;
        o_d.vld = 1'b0;
        if (mode == MODE_PASS) begin
            if (take) begin
                o_d.vld = 1'b1;
                o_d.dat = in_data;
            end
        end else if (step) begin
            o_d.vld = 1'b1;
            o_d.dat = y_next;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign out_valid = o_q.vld;
    assign out_data  = o_q.dat;

endmodule

// File: rtl/ups_iir_interp_chk.sv
module ups_iir_interp_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         bypass,
    input logic         in_valid,
    input logic         in_ready,
    input logic [W-1:0] in_data,
    input logic         out_strobe,
    input logic         out_valid,
    input logic [W-1:0] out_data
);
    // R2
    ready_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !bypass) |=> (!in_ready || bypass));

    // R3
    pulse_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(out_strobe || (in_valid && in_ready)));

    // R7
    pass_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |-> in_ready);

    // R7
    pass_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass && in_valid && in_ready) |=> (out_valid && out_data == $past(in_data)));

    // R9
    hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_data));

endmodule

bind ups_iir_interp ups_iir_interp_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bypass     (bypass),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_data    (in_data),
    .out_strobe (out_strobe),
    .out_valid  (out_valid),
    .out_data   (out_data)
);

// File: tb/ups_iir_interp_test.sv
module ups_iir_interp_test;
    localparam int W = 16;
    localparam int L = 8;
    localparam int K = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bypass = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [W-1:0] in_data = '0;
    logic         out_strobe = 1'b0;
    logic         out_valid;
    logic [W-1:0] out_data;

    int     checks = 0;
    int     errors = 0;
    longint y_m = 0;
    bit     done = 1'b0;

    always #2.5 clk = ~clk;

    ups_iir_interp #(.W(W), .L(L), .K(K)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bypass     (bypass),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_data    (in_data),
        .out_strobe (out_strobe),
        .out_valid  (out_valid),
        .out_data   (out_data)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint model_out();
        longint r = (y_m + (longint'(1) <<< (K - 1))) >>> K;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return r;
    endfunction

    function automatic void model_step(input longint x);
        y_m = y_m + (((x <<< K) - y_m) >>> K);
    endfunction

    task automatic send(input longint x);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = W'(x);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // L spaced strobes, each output checked one cycle after its strobe
    task automatic burst_spaced(input longint x);
        for (int i = 0; i < L; i++) begin
            chk("R2 ready low mid-burst", in_ready, 0);
            out_strobe = 1'b1;
            @(negedge clk);
            out_strobe = 1'b0;
            model_step(x);
            chk("R3 pulse", out_valid, 1);
            chk("R4 R5 value", longint'($signed(out_data)), model_out());
            @(negedge clk);
            chk("R3 single pulse", out_valid, 0);
        end
        chk("R2 ready after burst", in_ready, 1);
    endtask

    // L back-to-back strobes
    task automatic burst_tight(input longint x);
        out_strobe = 1'b1;
        for (int i = 0; i < L; i++) begin
            @(negedge clk);
            if (i == L - 1) out_strobe = 1'b0;
            model_step(x);
            chk("R3 pulse", out_valid, 1);
            chk("R4 R5 value", longint'($signed(out_data)), model_out());
        end
        chk("R2 ready after burst", in_ready, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset valid", out_valid, 0);
        chk("R1 reset ready", in_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", in_ready, 1);
        chk("R1 valid after reset", out_valid, 0);

        // R1: state zero, first output = round(x / 2^K)
        y_m = 0;
        send(1000);
        burst_spaced(1000);

        // R6: strobe while idle gives nothing and leaves state
        out_strobe = 1'b1;
        @(negedge clk);
        out_strobe = 1'b0;
        chk("R6 idle strobe", out_valid, 0);
        chk("R9 hold", longint'($signed(out_data)), model_out());

        // sweep including full-scale endpoints
        for (int i = 0; i < 26; i++) begin
            longint v;
            if (i == 24) v = 32767;
            else if (i == 25) v = -32768;
            else v = longint'((i * 7919 + 12345) % 65536) - 32768;
            send(v);
            if (i % 2 == 0) burst_spaced(v);
            else burst_tight(v);
        end
        // full-scale settling
        for (int i = 0; i < 6; i++) begin
            send(32767);
            burst_tight(32767);
        end
        for (int i = 0; i < 6; i++) begin
            send(-32768);
            burst_tight(-32768);
        end

        // R6: strobe in the acceptance cycle is ignored
        @(negedge clk);
        in_valid   = 1'b1;
        in_data    = W'(-500);
        out_strobe = 1'b1;
        @(negedge clk);
        in_valid   = 1'b0;
        out_strobe = 1'b0;
        chk("R6 strobe at accept", out_valid, 0);
        chk("R2 ready low after accept", in_ready, 0);
        burst_spaced(-500);

        // R7: bypass passes through, strobes ignored
        bypass = 1'b1;
        @(negedge clk);
        chk("R7 ready in bypass", in_ready, 1);
        in_valid   = 1'b1;
        in_data    = W'(4321);
        out_strobe = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R7 pass valid", out_valid, 1);
        chk("R7 pass data", longint'($signed(out_data)), 4321);
        chk("R7 ready", in_ready, 1);
        @(negedge clk);
        out_strobe = 1'b0;
        chk("R7 strobe ignored", out_valid, 0);
        chk("R9 hold", longint'($signed(out_data)), 4321);
        send(-1234);
        chk("R7 pass data", longint'($signed(out_data)), -1234);

        // R8: resume filtering from the bypassed value
        @(negedge clk);
        bypass = 1'b0;
        y_m = longint'(-1234) <<< K;
        send(-1234);
        for (int i = 0; i < L; i++) begin
            out_strobe = 1'b1;
            @(negedge clk);
            out_strobe = 1'b0;
            chk("R8 flat after bypass", longint'($signed(out_data)), -1234);
            @(negedge clk);
        end

        // R1: reset clears state again
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        y_m = 0;
        send(-20000);
        out_strobe = 1'b1;
        @(negedge clk);
        out_strobe = 1'b0;
        chk("R1 state cleared", longint'($signed(out_data)), -2500);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule